// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block sits beside a processor core and owns its two low-power states. When the core executes its sleep instruction it raises a one-cycle request, and the controller parks in either a light state (IDLE) or a deep state (SLEEP), chosen by a mode input sampled with that request. While it is parked, the clock-run output is low. The controller then waits for one of three wake sources: a timer timeout, a watchdog timeout or a level change on an external input port.

The wake path depends on the state. From IDLE the core resumes at the instruction after the sleep instruction. When the timer caused the wake, the controller also raises a sticky status flag and, one cycle later, requests the interrupt vector at 0x008. From SLEEP every wake becomes a single-cycle reset request, after which the core fetches from 0x000. The timer is a wake source only in IDLE. The watchdog and port sources count only if their enables were set at sleep entry. The port is compared bit by bit against a snapshot taken at entry, after a two-flop synchronizer on each pin.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, run_o is 1 and resume_o, rst_req_o, vec_req_o and tmr_flag_o are all 0.
- R2: A sleep_req_i pulse while running enters IDLE when sleep_mode_i is 0 and SLEEP when it is 1. From the next cycle run_o is 0.
- R3: A tmr_tmo_i pulse in IDLE produces a one-cycle resume_o in the cycle after the pulse. tmr_flag_o is set in that same cycle and stays set until a flag_clr_i pulse.
- R4: vec_req_o is a one-cycle pulse in the cycle after a resume_o caused by the timer. A wake from any other source gives no vector request.
- R5: Any wake in SLEEP produces exactly one cycle of rst_req_o and no resume_o.
- R6: run_o is 1 in the same cycle as the resume_o or rst_req_o strobe.
- R7: tmr_tmo_i in SLEEP is ignored: no wake, no flag, and run_o stays 0.
- R8: wdt_wake_en_i and port_wake_en_i are sampled at sleep entry. A disabled source never wakes, and changing an enable while parked has no effect.
- R9: With the port wake enabled, any bit of port_i that differs from its synchronized value at entry wakes the block. The strobe appears three cycles after the pin changes (two synchronizer stages plus the output register).
- R10: sleep_req_i is ignored while parked. The state and mode chosen at entry are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | One-cycle pulse when the sleep instruction executes |
| sleep_mode_i | input | 1 | 0 selects IDLE, 1 selects SLEEP |
| wdt_wake_en_i | input | 1 | Watchdog wake enable, sampled at entry |
| port_wake_en_i | input | 1 | Port wake enable, sampled at entry |
| tmr_tmo_i | input | 1 | Timer timeout pulse |
| wdt_tmo_i | input | 1 | Watchdog timeout pulse |
| port_i | input | PORT_W | External port pins (asynchronous) |
| flag_clr_i | input | 1 | Clears the timer-wake flag |
| run_o | output | 1 | Core clock may run (1 in RUN) |
| resume_o | output | 1 | One-cycle strobe: continue after the sleep instruction |
| rst_req_o | output | 1 | One-cycle reset request after a SLEEP wake |
| tmr_flag_o | output | 1 | Sticky timer-wake status flag (status bit 0) |
| vec_req_o | output | 1 | One-cycle request to vector to 0x008 |

## Verification
A wrong state register shows up at the ports within one cycle of the next wake. A stuck or mis-decoded mode turns the expected resume_o into rst_req_o, or the reverse, or leaves run_o low after the strobe. A stale entry snapshot or stale enable latch shows up as a wake that comes too early or never comes. The scoreboard catches both cases because it times every strobe to the exact cycle. A lost timer cause appears one cycle after resume as a missing vec_req_o, or as tmr_flag_o still 0.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2
  } lp_mode_e;
endpackage

// File: rtl/lp_port_sync.sv
module lp_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] port_i,
  output logic [W-1:0] port_s_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], port_i[i]};
    end
    assign port_s_o[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/lp_wake_detect.sv
module lp_wake_detect
  import lp_wake_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic         wdt_en_i,
  input  logic         port_en_i,
  input  logic [W-1:0] port_s_i,
  input  lp_mode_e     mode_i,
  input  logic         tmr_tmo_i,
  input  logic         wdt_tmo_i,
  output logic         wake_o,
  output logic         tmr_cause_o
);
  logic [W-1:0] snap_q;
  logic         wdt_en_q, port_en_q;
  logic         parked, port_hit, wdt_hit, tmr_hit;

  // enables and port snapshot are frozen at entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= '0;
      wdt_en_q  <= 1'b0;
      port_en_q <= 1'b0;
    end else if (arm_i) begin
      snap_q    <= port_s_i;
      wdt_en_q  <= wdt_en_i;
      port_en_q <= port_en_i;
    end
  end

  assign parked   = (mode_i != MODE_RUN);
  assign port_hit = port_en_q && (port_s_i != snap_q);
  assign wdt_hit  = wdt_en_q && wdt_tmo_i;
  assign tmr_hit  = (mode_i == MODE_IDLE) && tmr_tmo_i;

  assign wake_o      = parked && (port_hit || wdt_hit || tmr_hit);
  assign tmr_cause_o = tmr_hit;
endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_wake_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sleep_req_i,
  input  logic     sleep_mode_i,
  input  logic     wake_i,
  input  logic     tmr_cause_i,
  input  logic     flag_clr_i,
  output lp_mode_e mode_o,
  output logic     arm_o,
  output logic     resume_o,
  output logic     rst_req_o,
  output logic     vec_req_o,
  output logic     tmr_flag_o
);
  lp_mode_e mode_q, mode_d;
  logic     vec_pend_q;

  assign arm_o = (mode_q == MODE_RUN) && sleep_req_i;

  always_comb begin
    mode_d = mode_q;
    if (arm_o)       mode_d = sleep_mode_i ? MODE_SLEEP : MODE_IDLE;
    else if (wake_i) mode_d = MODE_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_RUN;
      resume_o   <= 1'b0;
      rst_req_o  <= 1'b0;
      vec_pend_q <= 1'b0;
      vec_req_o  <= 1'b0;
      tmr_flag_o <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      resume_o   <= wake_i && (mode_q == MODE_IDLE);
      rst_req_o  <= wake_i && (mode_q == MODE_SLEEP);
      vec_pend_q <= wake_i && tmr_cause_i;
      vec_req_o  <= vec_pend_q;
      if (wake_i && tmr_cause_i) tmr_flag_o <= 1'b1;
      else if (flag_clr_i)       tmr_flag_o <= 1'b0;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
  import lp_wake_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              sleep_mode_i,
  input  logic              wdt_wake_en_i,
  input  logic              port_wake_en_i,
  input  logic              tmr_tmo_i,
  input  logic              wdt_tmo_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              flag_clr_i,
  output logic              run_o,
  output logic              resume_o,
  output logic              rst_req_o,
  output logic              tmr_flag_o,
  output logic              vec_req_o
);
  logic [PORT_W-1:0] port_s;
  lp_mode_e          mode_q;
  logic              arm, wake, tmr_cause;

  lp_port_sync #(.W(PORT_W), .STAGES(SYNC_STGS)) u_sync (
    .clk_i, .rst_ni, .port_i, .port_s_o(port_s)
  );

  lp_wake_detect #(.W(PORT_W)) u_detect (
    .clk_i, .rst_ni,
    .arm_i(arm), .wdt_en_i(wdt_wake_en_i), .port_en_i(port_wake_en_i),
    .port_s_i(port_s), .mode_i(mode_q),
    .tmr_tmo_i, .wdt_tmo_i,
    .wake_o(wake), .tmr_cause_o(tmr_cause)
  );

  lp_mode_fsm u_fsm (
    .clk_i, .rst_ni, .sleep_req_i, .sleep_mode_i,
    .wake_i(wake), .tmr_cause_i(tmr_cause), .flag_clr_i,
    .mode_o(mode_q), .arm_o(arm),
    .resume_o, .rst_req_o, .vec_req_o, .tmr_flag_o
  );

  assign run_o = (mode_q == MODE_RUN);
endmodule

// File: rtl/lp_wake_chk.sv
module lp_wake_chk
  import lp_wake_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input lp_mode_e mode_q,
  input logic     run_o,
  input logic     resume_o,
  input logic     rst_req_o,
  input logic     vec_req_o,
  input logic     tmr_flag_o
);
  AST_RESUME_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> $past(mode_q) == MODE_IDLE); // R3
  AST_RST_FROM_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(mode_q) == MODE_SLEEP); // R5
  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R5
  AST_WAKE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resume_o && rst_req_o)); // R5
  AST_RUN_ON_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_o || rst_req_o) |-> run_o); // R6
  AST_VEC_AFTER_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> $past(resume_o)); // R4
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_flag_o) |-> resume_o); // R3
endmodule

bind lp_wake_ctrl lp_wake_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_q(mode_q), .run_o(run_o),
  .resume_o(resume_o), .rst_req_o(rst_req_o), .vec_req_o(vec_req_o),
  .tmr_flag_o(tmr_flag_o)
);

// File: tb/lp_wake_ctrl_tb.sv
`timescale 1ns/1ps
module lp_wake_ctrl_tb;
  localparam int PW = 8;
  localparam int K_RESUME = 0, K_RST = 1, K_VEC = 2;

  typedef struct { int kind; int cyc; string req; } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sleep_req = 0, sleep_mode = 0, wdt_en = 0, port_en = 0;
  logic tmr_tmo = 0, wdt_tmo = 0, flag_clr = 0;
  logic [PW-1:0] port = '0;
  logic run, resume, rst_req, tmr_flag, vec_req;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  lp_wake_ctrl #(.PORT_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .sleep_mode_i(sleep_mode),
    .wdt_wake_en_i(wdt_en), .port_wake_en_i(port_en), .tmr_tmo_i(tmr_tmo),
    .wdt_tmo_i(wdt_tmo), .port_i(port), .flag_clr_i(flag_clr),
    .run_o(run), .resume_o(resume), .rst_req_o(rst_req),
    .tmr_flag_o(tmr_flag), .vec_req_o(vec_req)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int kind, int dly, string req);
    exp_t e;
    e.kind = kind; e.cyc = cyc + dly; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic enter(logic mode);
    sleep_mode = mode; sleep_req = 1; tick(1); sleep_req = 0;
  endtask

  task automatic pulse_tmr(); tmr_tmo = 1; tick(1); tmr_tmo = 0; endtask
  task automatic pulse_wdt(); wdt_tmo = 1; tick(1); wdt_tmo = 0; endtask

  // monitor: every strobe must match the head of the queue
  task automatic observe(int kind);
    exp_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL unexpected strobe: actual kind %0d expected none (cycle %0d)", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.cyc != cyc) begin
        n_fail++;
        $display("FAIL %s: actual kind %0d cyc %0d expected kind %0d cyc %0d",
                 e.req, kind, cyc, e.kind, e.cyc);
      end
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    if (resume)  observe(K_RESUME);
    if (rst_req) observe(K_RST);
    if (vec_req) observe(K_VEC);
  end

  initial begin
    tick(3); rst_ni = 1; tick(1);
    // R1 reset state
    check("R1 run", run, 1); check("R1 resume", resume, 0);
    check("R1 rst_req", rst_req, 0); check("R1 flag", tmr_flag, 0);
    check("R1 vec", vec_req, 0);

    // R2/R3/R4 IDLE timer wake
    enter(0);
    check("R2 run low in IDLE", run, 0);
    tick(3);
    push(K_RESUME, 1, "R3 timer resume"); push(K_VEC, 2, "R4 vector");
    pulse_tmr();
    check("R3 flag set", tmr_flag, 1); check("R6 run on resume", run, 1);
    tick(3);
    check("R3 flag held", tmr_flag, 1);
    flag_clr = 1; tick(1); flag_clr = 0;
    check("R3 flag cleared", tmr_flag, 0);

    // R7 timer ignored in SLEEP; R5 watchdog reset
    wdt_en = 1; enter(1);
    check("R2 run low in SLEEP", run, 0);
    pulse_tmr(); tick(5);
    check("R7 still asleep", run, 0); check("R7 no flag", tmr_flag, 0);
    push(K_RST, 1, "R5 wdt reset");
    pulse_wdt();
    check("R6 run on reset", run, 1);
    tick(3);

    // R8 enable latched off; R9 port wake from IDLE (no vector: R4)
    wdt_en = 0; port_en = 1; enter(0);
    wdt_en = 1; tick(1);
    pulse_wdt(); tick(4);
    check("R8 wdt disabled at entry", run, 0);
    push(K_RESUME, 3, "R9 port resume");
    port[3] = 1; tick(5);
    check("R9 run after port wake", run, 1);
    check("R4 no flag on port wake", tmr_flag, 0);

    // R8 port disabled; wdt wakes
    port_en = 0; wdt_en = 1; enter(1);
    port_en = 1; port = 8'h5A; tick(6);
    check("R8 port disabled at entry", run, 0);
    push(K_RST, 1, "R8 wdt reset");
    pulse_wdt(); tick(4);

    // R9 port change from SLEEP, high bit
    port_en = 1; wdt_en = 0; enter(1); tick(2);
    push(K_RST, 3, "R9 port reset");
    port[7] = ~port[7]; tick(5);
    check("R9 run after sleep wake", run, 1);

    // R10 sleep request ignored while parked
    port_en = 0; enter(0); tick(1);
    enter(1); tick(2);
    check("R10 still parked", run, 0);
    push(K_RESUME, 1, "R10 stays IDLE"); push(K_VEC, 2, "R10 vector");
    pulse_tmr(); tick(4);
    check("R10 flag", tmr_flag, 1);

    tick(5);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule